// File: doc/BRIEF.md
# Host-Board Command Mailbox

This block is the register window through which a host processor and a daughter board pass commands to each other. The host writes a command word, a 16-bit offset-low word and a 32-bit parameter split over two 16-bit words, then writes a status word to ring the board. The block decodes the command into a two-bit group, a four-bit index, a 24-bit offset and a 32-bit parameter, and presents them to the board with a request interrupt.

System-group commands go to the board, which answers through a reply port. Commands in any other group are refused at once by the block itself. Every reply rewrites the command word: the command field is advanced by a fixed step and a result code is placed in the low byte. The reply also loads the offset and parameter words and raises an interrupt toward the host. Both interrupts appear in the status word as active-low bits.

Top module: `host_board_mailbox`

## Requirements
- R1: Host register select 0 is the command word. Bit 15 is the pending flag, bits 14:13 are the group, bits 12:9 are the index and bits 7:0 are offset bits 23:16. A host write there reads back unchanged, and `cmdGroup` and `cmdIndex` show the decoded fields.
- R2: Select 1 holds offset bits 15:0, select 2 holds parameter bits 15:0 and select 3 holds parameter bits 31:16. `cmdOffset` and `cmdParam` show the assembled values.
- R3: A host write to the status word (select 4) with bit 0 at 0, while the group is 0, sets `boardIrq` on the next clock. A status write with bit 0 at 1 leaves `boardIrq` unchanged.
- R4: A status write with bit 8 at 1 clears `hostIrq`. A status write with bit 8 at 0 leaves it unchanged.
- R5: A status read returns bit 8 as the inverse of `hostIrq` and bit 0 as the inverse of `boardIrq`, with every other bit at 1.
- R6: A board reply (`replyValid`) writes the command word as ((command AND 0x7E00) + 0x0400) truncated to 16 bits, ORed with 0x00FF when `replyFail` is set and with 0x0004 otherwise. It also loads offset-low from `replyOffsetLow` and the parameter from `replyParam`, sets `hostIrq` and clears `boardIrq`.
- R7: A status write with bit 0 at 0, while the group is 1, 2 or 3, produces a failure reply on the same clock. The command word is formatted as in R6 with code 0xFF, offset-low becomes 0, the parameter becomes 0xFFFFFFFF, `hostIrq` is set and `boardIrq` is not raised.
- R8: While `boardPresent` is 0, a read of the command word returns 0xFFFF. The other registers still read their stored values.
- R9: When a board reply and a host write target the same register on one clock, the reply value is stored. A reply on the same clock as a host-interrupt clear leaves `hostIrq` set.
- R10: After reset every register is 0, both interrupts are low, and the status word reads 0xFFFF.
- R11: Selects 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 3 | Host register select |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for `hostSel` |
| boardPresent | input | 1 | Board fitted; when low, the command word reads all ones |
| replyValid | input | 1 | Board reply strobe |
| replyFail | input | 1 | Board reply carries a failure code |
| replyOffsetLow | input | 16 | Offset-low value loaded by a board reply |
| replyParam | input | 32 | Parameter value loaded by a board reply |
| boardIrq | output | 1 | Request interrupt toward the board |
| hostIrq | output | 1 | Interrupt toward the host |
| cmdGroup | output | 2 | Decoded command group |
| cmdIndex | output | 4 | Decoded command index within the group |
| cmdOffset | output | 24 | Assembled 24-bit offset |
| cmdParam | output | 32 | Assembled 32-bit parameter |

## Verification
The bench builds the block with its default reply step of 0x0400 and result codes 0xFF and 0x04. With these values the expected reply words can be worked out by hand. A top command number of 0x3F, advanced by the step, carries into the pending bit and gives 0x82FF, so the wrap case can be reached directly. The same values let failure and success codes be told apart in the offset byte that the board sees.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W   = 16;
  localparam int PARAM_W = 2 * REG_W;
  localparam int OFFS_W  = 24;
  localparam int SEL_W   = 3;

  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_OFFS = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PARL = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PARH = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;

  // command number field (group + index) kept by a reply
  localparam logic [REG_W-1:0] FIELD_MASK = 16'h7E00;

  typedef struct packed {
    logic wrCmd;
    logic wrOffs;
    logic wrParL;
    logic wrParH;
    logic raiseBoard;
    logic clearHost;
    logic loadReply;
    logic replyBad;
    logic autoMode;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic             hostWrEn,
  input  logic [SEL_W-1:0] hostSel,
  input  logic             statBit0,
  input  logic             statBit8,
  input  logic [1:0]       cmdGroup,
  input  logic             replyValid,
  input  logic             replyFail,
  output mboxStrobes_t     strobes
);
  logic statusWr;
  logic ringReq;
  logic isSystem;

  always_comb begin
    statusWr = hostWrEn && (hostSel == SEL_STAT);
    ringReq  = statusWr && !statBit0;
    isSystem = (cmdGroup == 2'd0);

    strobes.wrCmd      = hostWrEn && (hostSel == SEL_CMD);
    strobes.wrOffs     = hostWrEn && (hostSel == SEL_OFFS);
    strobes.wrParL     = hostWrEn && (hostSel == SEL_PARL);
    strobes.wrParH     = hostWrEn && (hostSel == SEL_PARH);
    strobes.raiseBoard = ringReq && isSystem;
    strobes.clearHost  = statusWr && statBit8;
    // a board reply outranks the block's own refusal
    strobes.autoMode   = !replyValid;
    strobes.loadReply  = replyValid || (ringReq && !isSystem);
    strobes.replyBad   = replyValid ? replyFail : 1'b1;
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter logic [REG_W-1:0] REPLY_INC = 16'h0400,
  parameter logic [7:0]       FAIL_CODE = 8'hFF,
  parameter logic [7:0]       OK_CODE   = 8'h04
) (
  input  logic               clk,
  input  logic               rstN,
  input  mboxStrobes_t       strobes,
  input  logic [REG_W-1:0]   hostWrData,
  input  logic [SEL_W-1:0]   hostSel,
  input  logic               boardPresent,
  input  logic [REG_W-1:0]   replyOffsetLow,
  input  logic [PARAM_W-1:0] replyParam,
  output logic [REG_W-1:0]   hostRdData,
  output logic               boardIrq,
  output logic               hostIrq,
  output logic [1:0]         cmdGroup,
  output logic [3:0]         cmdIndex,
  output logic [OFFS_W-1:0]  cmdOffset,
  output logic [PARAM_W-1:0] cmdParam
);
  logic [REG_W-1:0]   cmdReg, offsReg, parLReg, parHReg;
  logic [REG_W-1:0]   replyWord;
  logic [REG_W-1:0]   nextOffs;
  logic [PARAM_W-1:0] nextParam;
  logic [REG_W-1:0]   statusWord;

  always_comb begin
    replyWord = ((cmdReg & FIELD_MASK) + REPLY_INC)
              | {8'h00, (strobes.replyBad ? FAIL_CODE : OK_CODE)};
    nextOffs  = strobes.autoMode ? '0 : replyOffsetLow;
    nextParam = strobes.autoMode ? '1 : replyParam;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      offsReg <= '0;
      parLReg <= '0;
      parHReg <= '0;
    end else begin
      if (strobes.loadReply)   cmdReg <= replyWord;
      else if (strobes.wrCmd)  cmdReg <= hostWrData;
      if (strobes.loadReply)   offsReg <= nextOffs;
      else if (strobes.wrOffs) offsReg <= hostWrData;
      if (strobes.loadReply)   parLReg <= nextParam[REG_W-1:0];
      else if (strobes.wrParL) parLReg <= hostWrData;
      if (strobes.loadReply)   parHReg <= nextParam[PARAM_W-1:REG_W];
      else if (strobes.wrParH) parHReg <= hostWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostIrq  <= 1'b0;
      boardIrq <= 1'b0;
    end else begin
      if (strobes.loadReply)      hostIrq <= 1'b1;
      else if (strobes.clearHost) hostIrq <= 1'b0;
      if (strobes.raiseBoard)                           boardIrq <= 1'b1;
      else if (strobes.loadReply && !strobes.autoMode) boardIrq <= 1'b0;
    end
  end

  always_comb begin
    statusWord    = '1;
    statusWord[8] = ~hostIrq;
    statusWord[0] = ~boardIrq;
    case (hostSel)
      SEL_CMD:  hostRdData = boardPresent ? cmdReg : '1;
      SEL_OFFS: hostRdData = offsReg;
      SEL_PARL: hostRdData = parLReg;
      SEL_PARH: hostRdData = parHReg;
      SEL_STAT: hostRdData = statusWord;
      default:  hostRdData = '0;
    endcase
  end

  assign cmdGroup  = cmdReg[14:13];
  assign cmdIndex  = cmdReg[12:9];
  assign cmdOffset = {cmdReg[7:0], offsReg};
  assign cmdParam  = {parHReg, parLReg};
endmodule

// File: rtl/host_board_mailbox.sv
module host_board_mailbox
  import mbox_pkg::*;
#(
  parameter logic [REG_W-1:0] REPLY_INC = 16'h0400,
  parameter logic [7:0]       FAIL_CODE = 8'hFF,
  parameter logic [7:0]       OK_CODE   = 8'h04
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [SEL_W-1:0]   hostSel,
  input  logic [REG_W-1:0]   hostWrData,
  output logic [REG_W-1:0]   hostRdData,
  input  logic               boardPresent,
  input  logic               replyValid,
  input  logic               replyFail,
  input  logic [REG_W-1:0]   replyOffsetLow,
  input  logic [PARAM_W-1:0] replyParam,
  output logic               boardIrq,
  output logic               hostIrq,
  output logic [1:0]         cmdGroup,
  output logic [3:0]         cmdIndex,
  output logic [OFFS_W-1:0]  cmdOffset,
  output logic [PARAM_W-1:0] cmdParam
);
  mboxStrobes_t strobes;

  mbox_ctrl u_ctrl (
    .hostWrEn   (hostWrEn),
    .hostSel    (hostSel),
    .statBit0   (hostWrData[0]),
    .statBit8   (hostWrData[8]),
    .cmdGroup   (cmdGroup),
    .replyValid (replyValid),
    .replyFail  (replyFail),
    .strobes    (strobes)
  );

  mbox_dpath #(
    .REPLY_INC (REPLY_INC),
    .FAIL_CODE (FAIL_CODE),
    .OK_CODE   (OK_CODE)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .hostWrData     (hostWrData),
    .hostSel        (hostSel),
    .boardPresent   (boardPresent),
    .replyOffsetLow (replyOffsetLow),
    .replyParam     (replyParam),
    .hostRdData     (hostRdData),
    .boardIrq       (boardIrq),
    .hostIrq        (hostIrq),
    .cmdGroup       (cmdGroup),
    .cmdIndex       (cmdIndex),
    .cmdOffset      (cmdOffset),
    .cmdParam       (cmdParam)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter logic [7:0] FAIL_CODE = 8'hFF,
  parameter logic [7:0] OK_CODE   = 8'h04
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [2:0]  hostSel,
  input logic [15:0] hostWrData,
  input logic [15:0] hostRdData,
  input logic        boardPresent,
  input logic        replyValid,
  input logic        replyFail,
  input logic [15:0] replyOffsetLow,
  input logic [31:0] replyParam,
  input logic        boardIrq,
  input logic        hostIrq,
  input logic [1:0]  cmdGroup,
  input logic [23:0] cmdOffset,
  input logic [31:0] cmdParam
);
  logic statWr;
  assign statWr = hostWrEn && (hostSel == 3'd4);

  a_r3_ring_raises_board: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !hostWrData[0] && cmdGroup == 2'd0) |=> boardIrq);

  a_r4_clear_host: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && hostWrData[8] && !replyValid && (hostWrData[0] || cmdGroup == 2'd0))
    |=> !hostIrq);

  a_r4_zero_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !hostWrData[8] && !replyValid && (hostWrData[0] || cmdGroup == 2'd0))
    |=> hostIrq == $past(hostIrq));

  a_r6_reply_loads: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |=> (hostIrq && !boardIrq && cmdOffset[15:0] == $past(replyOffsetLow)
                    && cmdParam == $past(replyParam)));

  a_r6_result_code: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |=> cmdOffset[23:16] == ($past(replyFail) ? FAIL_CODE : OK_CODE));

  a_r7_refusal: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !hostWrData[0] && cmdGroup != 2'd0 && !replyValid)
    |=> (hostIrq && cmdOffset == {FAIL_CODE, 16'h0000} && cmdParam == 32'hFFFFFFFF));

  a_r8_absent_reads_ones: assert property (@(posedge clk) disable iff (!rstN)
    (!boardPresent && hostSel == 3'd0) |-> hostRdData == 16'hFFFF);
endmodule

bind host_board_mailbox mbox_checker #(
  .FAIL_CODE (FAIL_CODE),
  .OK_CODE   (OK_CODE)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .hostWrEn       (hostWrEn),
  .hostSel        (hostSel),
  .hostWrData     (hostWrData),
  .hostRdData     (hostRdData),
  .boardPresent   (boardPresent),
  .replyValid     (replyValid),
  .replyFail      (replyFail),
  .replyOffsetLow (replyOffsetLow),
  .replyParam     (replyParam),
  .boardIrq       (boardIrq),
  .hostIrq        (hostIrq),
  .cmdGroup       (cmdGroup),
  .cmdOffset      (cmdOffset),
  .cmdParam       (cmdParam)
);

// File: tb/sim_host_board_mailbox.sv
`timescale 1ns/1ps
module sim_host_board_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostSel = 3'd0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        boardPresent = 1'b1;
  logic        replyValid = 1'b0;
  logic        replyFail = 1'b0;
  logic [15:0] replyOffsetLow = '0;
  logic [31:0] replyParam = '0;
  logic        boardIrq, hostIrq;
  logic [1:0]  cmdGroup;
  logic [3:0]  cmdIndex;
  logic [23:0] cmdOffset;
  logic [31:0] cmdParam;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  host_board_mailbox u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .boardPresent(boardPresent),
    .replyValid(replyValid), .replyFail(replyFail), .replyOffsetLow(replyOffsetLow),
    .replyParam(replyParam), .boardIrq(boardIrq), .hostIrq(hostIrq),
    .cmdGroup(cmdGroup), .cmdIndex(cmdIndex), .cmdOffset(cmdOffset), .cmdParam(cmdParam)
  );

  // {select, write data, expected read-back}
  localparam logic [34:0] VEC [8] = '{
    {3'd0, 16'h8600, 16'h8600},
    {3'd1, 16'hBEEF, 16'hBEEF},
    {3'd2, 16'h1357, 16'h1357},
    {3'd3, 16'h2468, 16'h2468},
    {3'd5, 16'h5555, 16'h0000},
    {3'd7, 16'hAAAA, 16'h0000},
    {3'd0, 16'h1A05, 16'h1A05},
    {3'd1, 16'h00C3, 16'h00C3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = sel; hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] sel, output logic [15:0] data);
    hostSel = sel;
    #0.5;
    data = hostRdData;
  endtask

  task automatic boardReply(input logic fail, input logic [15:0] offs, input logic [31:0] par);
    @(negedge clk);
    replyValid = 1'b1; replyFail = fail; replyOffsetLow = offs; replyParam = par;
    @(negedge clk);
    replyValid = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    hostRead(3'd4, rd); check("R10 status after reset", rd, 16'hFFFF);
    hostRead(3'd0, rd); check("R10 command after reset", rd, 16'h0000);
    check("R10 irqs after reset", {hostIrq, boardIrq}, 2'b00);

    // R1 R2 R11 table walk
    foreach (VEC[i]) begin
      hostWrite(VEC[i][34:32], VEC[i][31:16]);
      hostRead(VEC[i][34:32], rd);
      check($sformatf("R1/R2/R11 vector %0d", i), rd, VEC[i][15:0]);
    end
    hostRead(3'd1, rd); check("R11 writes to spare selects ignored", rd, 16'h00C3);
    check("R1 group decode", cmdGroup, 2'd0);
    check("R1 index decode", cmdIndex, 4'hD);
    check("R2 offset assembly", cmdOffset, 24'h0500C3);
    check("R2 param assembly", cmdParam, 32'h24681357);

    // R3 bit0=1 has no effect; R5 status
    hostWrite(3'd4, 16'h0101);
    check("R3 bit0 high no ring", boardIrq, 1'b0);
    hostWrite(3'd4, 16'h0000);
    check("R3 ring system group", boardIrq, 1'b1);
    hostRead(3'd4, rd); check("R5 status board pending", rd, 16'hFFFE);

    // R6 success reply
    boardReply(1'b0, 16'h4321, 32'hCAFEF00D);
    hostRead(3'd0, rd); check("R6 ok reply word", rd, 16'h1E04);
    check("R6 reply offset", cmdOffset[15:0], 16'h4321);
    check("R6 reply param", cmdParam, 32'hCAFEF00D);
    check("R6 irqs after reply", {hostIrq, boardIrq}, 2'b10);
    hostRead(3'd4, rd); check("R5 status host pending", rd, 16'hFEFF);

    // R4
    hostWrite(3'd4, 16'h0001);
    check("R4 zero in bit8 ignored", hostIrq, 1'b1);
    hostWrite(3'd4, 16'h0101);
    check("R4 clear host irq", hostIrq, 1'b0);

    // R7 refusal of network group
    hostWrite(3'd0, 16'h2C33);
    check("R7 group decode", cmdGroup, 2'd1);
    hostWrite(3'd4, 16'h0000);
    hostRead(3'd0, rd); check("R7 refusal word", rd, 16'h30FF);
    hostRead(3'd1, rd); check("R7 refusal offset", rd, 16'h0000);
    hostRead(3'd2, rd); check("R7 refusal param low", rd, 16'hFFFF);
    hostRead(3'd3, rd); check("R7 refusal param high", rd, 16'hFFFF);
    check("R7 irqs after refusal", {hostIrq, boardIrq}, 2'b10);
    hostWrite(3'd4, 16'h0101);

    // R7 unknown group with carry into pending bit
    hostWrite(3'd0, 16'h7E12);
    hostWrite(3'd4, 16'h0000);
    hostRead(3'd0, rd); check("R7 wrap refusal word", rd, 16'h82FF);
    hostWrite(3'd4, 16'h0101);

    // R6 failure reply from board
    hostWrite(3'd0, 16'h0000);
    hostWrite(3'd4, 16'h0000);
    check("R3 ring second", boardIrq, 1'b1);
    boardReply(1'b1, 16'h0011, 32'h0);
    hostRead(3'd0, rd); check("R6 fail reply word", rd, 16'h04FF);
    check("R6 board irq cleared", boardIrq, 1'b0);

    // R9 reply beats host write on command register
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = 3'd0; hostWrData = 16'h1234;
    replyValid = 1'b1; replyFail = 1'b1; replyOffsetLow = 16'h0AAA; replyParam = 32'h1;
    @(negedge clk);
    hostWrEn = 1'b0; replyValid = 1'b0;
    hostRead(3'd0, rd); check("R9 reply wins command", rd, 16'h08FF);
    // R9 reply beats host-interrupt clear
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = 3'd4; hostWrData = 16'h0101;
    replyValid = 1'b1; replyFail = 1'b0;
    @(negedge clk);
    hostWrEn = 1'b0; replyValid = 1'b0;
    check("R9 reply wins host irq", hostIrq, 1'b1);
    hostRead(3'd0, rd); check("R9 second reply word", rd, 16'h0C04);

    // R8 board absent
    boardPresent = 1'b0;
    hostRead(3'd0, rd); check("R8 absent command", rd, 16'hFFFF);
    hostRead(3'd1, rd); check("R8 absent offset unaffected", rd, 16'h0AAA);
    boardPresent = 1'b1;
    hostRead(3'd0, rd); check("R8 present again", rd, 16'h0C04);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule